// File: doc/BRIEF.md
# Processor Trap Entry Controller

This block carries out the architectural state change that a 64-bit processor with windowed registers makes on taking a trap. When a one-cycle trap strobe arrives, it samples the current trap level, condition codes, address-space identifier, processor-state word, window pointer, window save count, global level, program counters and trap base address. In the same clock edge it:

- raises the trap level;
- records a trap-stack entry for the new level;
- loads a new processor-state word and window pointer;
- advances the global level;
- produces the new PC/NPC pair pointing into the trap table.

A done pulse follows one cycle later. A trap that arrives when the level is already at its ceiling does none of this: the block enters a sticky error state that only reset clears.

The control path is a three-state machine. ST_IDLE waits for a strobe. ST_DONE is held for exactly one cycle after each accepted trap and accepts a new strobe itself. ST_HALT is the error state.

Transitions:
- T_ACCEPT: from ST_IDLE or ST_DONE to ST_DONE on a strobe with an in-range level.
- T_OVERFLOW: from ST_IDLE or ST_DONE to ST_HALT on a strobe with the level at or above the ceiling.
- T_RELAX: from ST_DONE to ST_IDLE with no strobe.
- T_STAY: ST_HALT stays in ST_HALT.

A read port exposes any stored trap-stack level.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset `new_tl`, `new_pstate`, `new_cwp`, `new_gl`, `new_pc` and `new_npc` are zero, `done_o` and `err_o` are low, and every trap-stack level reads back as zero.
- R2: An accepted trap with `cur_tl` below MAXTL-1 sets `new_tl` to `cur_tl`+1 and leaves the RED bit (PSTATE bit 5) clear in `new_pstate`.
- R3: An accepted trap with `cur_tl` equal to MAXTL-1 sets `new_tl` to MAXTL and sets the RED bit (bit 5) in `new_pstate`.
- R4: A strobe with `cur_tl` at or above MAXTL raises `err_o` one cycle later with no `done_o`. `err_o` then stays high until reset, all outputs and trap-stack contents keep their values, and later strobes have no effect.
- R5: The saved state word holds `cur_gl` in bits [42:40] and `cur_ccr` in [39:32]. It holds `cur_asi` in [31:24], and in [19:8] it holds `cur_pstate` masked with 0xF3F, with RED (bit 5) ORed in before masking when the same trap sets it. `cur_cwp` sits in the low bits and all other bits are zero.
- R6: Each accepted trap sets `new_gl` to `cur_gl`+1 modulo 8.
- R7: The trap-stack level equal to the new trap level (read with `rd_lvl`, 1..MAXTL) receives the saved state word, `cur_pc`, `cur_npc` and the trap type. Other levels keep their contents, and `rd_lvl` 0 reads zero.
- R8: Trap types 0x008, 0x030 and 0x064..0x06F set `new_pstate` to 0x414 (MMU globals, privileged, FP enabled), plus RED when R3 applies.
- R9: Trap type 0x060 sets `new_pstate` to 0x814 (interrupt globals). Every other type sets `new_pstate` to 0x015 (alternate globals), each plus RED when R3 applies.
- R10: Window pointer arithmetic is modulo NWIN. Type 0x024 gives `new_cwp` = `cur_cwp`-1. A type whose bits [8:6] are 010 gives `cur_cwp`-`cur_cansave`-2, a type whose bits [8:6] are 011 gives `cur_cwp`+1, and any other type leaves `cur_cwp` unchanged.
- R11: `new_pc` is `trap_base` with bits [14:0] cleared, ORed with bit 14 when the new level exceeds 1 and with the trap type in bits [13:5]. `new_npc` is `new_pc`+4.
- R12: All outputs of an accepted trap change at the clock edge that samples the strobe, and `done_o` is high for exactly the following cycle. A strobe in that done cycle is accepted as a further trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_vld | input | 1 | Trap strobe, one cycle per trap |
| trap_tt | input | 9 | Trap type |
| cur_tl | input | TLW (3) | Current trap level |
| cur_ccr | input | 8 | Condition codes |
| cur_asi | input | 8 | Address-space identifier |
| cur_pstate | input | 12 | Current processor-state word |
| cur_cwp | input | CWPW (3) | Current window pointer |
| cur_cansave | input | CWPW (3) | Windows free to save |
| cur_gl | input | 3 | Current global level |
| cur_pc | input | 64 | Current PC |
| cur_npc | input | 64 | Current next PC |
| trap_base | input | 64 | Trap table base address |
| rd_lvl | input | TLW (3) | Trap-stack read level |
| new_tl | output | TLW (3) | Raised trap level |
| new_pstate | output | 12 | New processor-state word |
| new_cwp | output | CWPW (3) | New window pointer |
| new_gl | output | 3 | New global level |
| new_pc | output | 64 | Trap vector |
| new_npc | output | 64 | Trap vector plus 4 |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky overflow error |
| rd_tstate | output | 64 | Stored state word at `rd_lvl` |
| rd_tpc | output | 64 | Stored PC at `rd_lvl` |
| rd_tnpc | output | 64 | Stored next PC at `rd_lvl` |
| rd_tt | output | 9 | Stored trap type at `rd_lvl` |

## Verification
Every registered result of an accepted trap becomes visible one edge after the strobe is sampled, together with `done_o`. The level, state word, window pointer, global level, vector pair and trap-stack entry are therefore all due in the cycle where `done_o` is high. The trap-stack read port is combinational, so a stored entry can be read in that same cycle. The bench drives inputs on the falling edge, and its monitor pops an expected record only on a falling edge that shows `done_o`, reading the stack just after that. Overflow is checked one falling edge after its strobe, and its absence of effect two edges later.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XLEN  = 64;
    localparam int TTW   = 9;
    localparam int PSW   = 12;
    localparam int GLW   = 3;

    // processor-state bits used by trap entry
    localparam logic [PSW-1:0] PS_ALTG  = 12'h001;
    localparam logic [PSW-1:0] PS_PRIV  = 12'h004;
    localparam logic [PSW-1:0] PS_FPEN  = 12'h010;
    localparam logic [PSW-1:0] PS_RED   = 12'h020;
    localparam logic [PSW-1:0] PS_MMUG  = 12'h400;
    localparam logic [PSW-1:0] PS_INTG  = 12'h800;
    localparam logic [PSW-1:0] PS_SAVE_MASK = 12'hF3F;

    // trap type codes whose behaviour differs
    localparam logic [TTW-1:0] TT_IFAULT  = 9'h008;
    localparam logic [TTW-1:0] TT_DFAULT  = 9'h030;
    localparam logic [TTW-1:0] TT_INTVEC  = 9'h060;
    localparam logic [TTW-1:0] TT_MMU_LO  = 9'h064;
    localparam logic [TTW-1:0] TT_MMU_HI  = 9'h06F;
    localparam logic [TTW-1:0] TT_CLEANW  = 9'h024;
    localparam logic [2:0]     TT_SPILL_GRP = 3'b010;
    localparam logic [2:0]     TT_FILL_GRP  = 3'b011;

    typedef struct packed {
        logic [XLEN-1:0] tstate;
        logic [XLEN-1:0] tpc;
        logic [XLEN-1:0] tnpc;
        logic [TTW-1:0]  tt;
    } trap_rec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DONE = 2'd1,
        ST_HALT = 2'd2
    } trap_fsm_t;
endpackage

// File: rtl/trap_level_step.sv
module trap_level_step #(
    parameter int MAXTL = 6,
    parameter int TLW   = 3
) (
    input  logic [TLW-1:0] cur_tl,
    output logic [TLW-1:0] nxt_tl,
    output logic           red_set,
    output logic           ovf
);
    localparam logic [TLW-1:0] CEIL    = TLW'(MAXTL);
    localparam logic [TLW-1:0] CEIL_M1 = TLW'(MAXTL - 1);

    always_comb begin
        ovf     = (cur_tl >= CEIL);
        red_set = !ovf && (cur_tl == CEIL_M1);
        nxt_tl  = cur_tl + TLW'(1);
    end
endmodule

// File: rtl/trap_mode_sel.sv
module trap_mode_sel
    import trap_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CWPW = 3
) (
    input  logic [TTW-1:0]  tt,
    input  logic            red_set,
    input  logic [CWPW-1:0] cwp,
    input  logic [CWPW-1:0] cansave,
    output logic [PSW-1:0]  pstate_nxt,
    output logic [CWPW-1:0] cwp_nxt
);
    logic mmu_kind;
    logic int_kind;
    int unsigned w_dec1;
    int unsigned w_spill;
    int unsigned w_inc1;

    always_comb begin
        mmu_kind = (tt == TT_IFAULT) || (tt == TT_DFAULT) ||
                   ((tt >= TT_MMU_LO) && (tt <= TT_MMU_HI));
        int_kind = (tt == TT_INTVEC);
        pstate_nxt = PS_PRIV | PS_FPEN;
        if (mmu_kind) begin
            pstate_nxt = pstate_nxt | PS_MMUG;
        end else if (int_kind) begin
            pstate_nxt = pstate_nxt | PS_INTG;
        end else begin
            pstate_nxt = pstate_nxt | PS_ALTG;
        end
        if (red_set) begin
            pstate_nxt = pstate_nxt | PS_RED;
        end
    end

    always_comb begin
        w_dec1  = (32'(cwp) + 32'(NWIN) - 32'd1) % 32'(NWIN);
        w_spill = (32'(cwp) + 32'(2 * NWIN) - 32'(cansave) - 32'd2) % 32'(NWIN);
        w_inc1  = (32'(cwp) + 32'd1) % 32'(NWIN);
        if (tt == TT_CLEANW) begin
            cwp_nxt = CWPW'(w_dec1);
        end else if (tt[8:6] == TT_SPILL_GRP) begin
            cwp_nxt = CWPW'(w_spill);
        end else if (tt[8:6] == TT_FILL_GRP) begin
            cwp_nxt = CWPW'(w_inc1);
        end else begin
            cwp_nxt = cwp;
        end
    end
endmodule

// File: rtl/trap_frame.sv
module trap_frame
    import trap_pkg::*;
#(
    parameter int TLW    = 3,
    parameter int CWPW   = 3,
    parameter bit HAS_GL = 1'b1
) (
    input  logic [7:0]      ccr,
    input  logic [7:0]      asi,
    input  logic [PSW-1:0]  pstate,
    input  logic            red_set,
    input  logic [CWPW-1:0] cwp,
    input  logic [GLW-1:0]  gl,
    input  logic [TTW-1:0]  tt,
    input  logic [TLW-1:0]  nxt_tl,
    input  logic [XLEN-1:0] tba,
    output logic [XLEN-1:0] tstate,
    output logic [XLEN-1:0] vec_pc,
    output logic [XLEN-1:0] vec_npc
);
    localparam logic [TLW-1:0] ONE = TLW'(1);
    logic [PSW-1:0] ps_saved;

    always_comb begin
        ps_saved = (pstate | (red_set ? PS_RED : '0)) & PS_SAVE_MASK;
        tstate   = '0;
        tstate[39:32] = ccr;
        tstate[31:24] = asi;
        tstate[19:8]  = ps_saved;
        tstate[CWPW-1:0] = cwp;
        if (HAS_GL) begin
            tstate[42:40] = gl;
        end
    end

    always_comb begin
        vec_pc = tba & ~64'h7FFF;
        if (nxt_tl > ONE) begin
            vec_pc[14] = 1'b1;
        end
        vec_pc[13:5] = tt;
        vec_npc = vec_pc + 64'd4;
    end
endmodule

// File: rtl/trap_stack.sv
module trap_stack
    import trap_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int TLW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [TLW-1:0]  wr_lvl,
    input  trap_rec_t       wr_rec,
    input  logic [TLW-1:0]  rd_lvl,
    output trap_rec_t       rd_rec
);
    trap_rec_t ent [DEPTH];

    // levels are 1-based: entry i holds level i+1
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                ent[i] <= '0;
            end else if (wr_en && (wr_lvl == TLW'(i + 1))) begin
                ent[i] <= wr_rec;
            end
        end
    end

    always_comb begin
        rd_rec = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_lvl == TLW'(i + 1)) begin
                rd_rec = ent[i];
            end
        end
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int MAXTL  = 6,
    parameter bit HAS_GL = 1'b1,
    localparam int TLW   = $clog2(MAXTL + 1),
    localparam int CWPW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_vld,
    input  logic [8:0]      trap_tt,
    input  logic [TLW-1:0]  cur_tl,
    input  logic [7:0]      cur_ccr,
    input  logic [7:0]      cur_asi,
    input  logic [11:0]     cur_pstate,
    input  logic [CWPW-1:0] cur_cwp,
    input  logic [CWPW-1:0] cur_cansave,
    input  logic [2:0]      cur_gl,
    input  logic [63:0]     cur_pc,
    input  logic [63:0]     cur_npc,
    input  logic [63:0]     trap_base,
    input  logic [TLW-1:0]  rd_lvl,
    output logic [TLW-1:0]  new_tl,
    output logic [11:0]     new_pstate,
    output logic [CWPW-1:0] new_cwp,
    output logic [2:0]      new_gl,
    output logic [63:0]     new_pc,
    output logic [63:0]     new_npc,
    output logic            done_o,
    output logic            err_o,
    output logic [63:0]     rd_tstate,
    output logic [63:0]     rd_tpc,
    output logic [63:0]     rd_tnpc,
    output logic [8:0]      rd_tt
);
    trap_fsm_t state_q, state_d;

    logic [TLW-1:0]  nxt_tl;
    logic            red_set;
    logic            ovf;
    logic [PSW-1:0]  pstate_nxt;
    logic [CWPW-1:0] cwp_nxt;
    logic [XLEN-1:0] tstate;
    logic [XLEN-1:0] vec_pc;
    logic [XLEN-1:0] vec_npc;
    logic            live;
    logic            accept;
    trap_rec_t       wr_rec;
    trap_rec_t       rd_rec;

    trap_level_step #(.MAXTL(MAXTL), .TLW(TLW)) u_level (
        .cur_tl  (cur_tl),
        .nxt_tl  (nxt_tl),
        .red_set (red_set),
        .ovf     (ovf)
    );

    trap_mode_sel #(.NWIN(NWIN), .CWPW(CWPW)) u_mode (
        .tt         (trap_tt),
        .red_set    (red_set),
        .cwp        (cur_cwp),
        .cansave    (cur_cansave),
        .pstate_nxt (pstate_nxt),
        .cwp_nxt    (cwp_nxt)
    );

    trap_frame #(.TLW(TLW), .CWPW(CWPW), .HAS_GL(HAS_GL)) u_frame (
        .ccr     (cur_ccr),
        .asi     (cur_asi),
        .pstate  (cur_pstate),
        .red_set (red_set),
        .cwp     (cur_cwp),
        .gl      (cur_gl),
        .tt      (trap_tt),
        .nxt_tl  (nxt_tl),
        .tba     (trap_base),
        .tstate  (tstate),
        .vec_pc  (vec_pc),
        .vec_npc (vec_npc)
    );

    always_comb begin
        live   = (state_q != ST_HALT);
        accept = live && trap_vld && !ovf;
        wr_rec = '{tstate: tstate, tpc: cur_pc, tnpc: cur_npc, tt: trap_tt};
    end

    trap_stack #(.DEPTH(MAXTL), .TLW(TLW)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept),
        .wr_lvl (nxt_tl),
        .wr_rec (wr_rec),
        .rd_lvl (rd_lvl),
        .rd_rec (rd_rec)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (trap_vld && ovf) begin
                    state_d = ST_HALT;          // T_OVERFLOW
                end else if (trap_vld) begin
                    state_d = ST_DONE;          // T_ACCEPT
                end else begin
                    state_d = ST_IDLE;          // T_RELAX
                end
            end
            ST_HALT: state_d = ST_HALT;         // T_STAY
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // committed architectural results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_tl     <= '0;
            new_pstate <= '0;
            new_cwp    <= '0;
            new_gl     <= '0;
            new_pc     <= '0;
            new_npc    <= '0;
        end else if (accept) begin
            new_tl     <= nxt_tl;
            new_pstate <= pstate_nxt;
            new_cwp    <= cwp_nxt;
            new_gl     <= HAS_GL ? cur_gl + 3'd1 : cur_gl;
            new_pc     <= vec_pc;
            new_npc    <= vec_npc;
        end
    end

    // state-decoded outputs
    always_comb begin
        done_o    = (state_q == ST_DONE);
        err_o     = (state_q == ST_HALT);
        rd_tstate = rd_rec.tstate;
        rd_tpc    = rd_rec.tpc;
        rd_tnpc   = rd_rec.tnpc;
        rd_tt     = rd_rec.tt;
    end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int MAXTL = 6,
    parameter int TLW   = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           trap_vld,
    input logic [TLW-1:0] cur_tl,
    input logic [TLW-1:0] new_tl,
    input logic [11:0]    new_pstate,
    input logic [63:0]    new_pc,
    input logic [63:0]    new_npc,
    input logic           done_o,
    input logic           err_o
);
    localparam logic [TLW-1:0] CEIL    = TLW'(MAXTL);
    localparam logic [TLW-1:0] CEIL_M1 = TLW'(MAXTL - 1);

    // R12
    accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_vld && !err_o && cur_tl < CEIL) |=> done_o);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_vld && !err_o && cur_tl >= CEIL) |=> (err_o && !done_o));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (err_o && $stable(new_tl) && $stable(new_pc)));

    // R2
    tl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_vld && !err_o && cur_tl < CEIL) |=> (new_tl == $past(cur_tl) + 1'b1));

    // R3
    red_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_vld && !err_o && cur_tl == CEIL_M1) |=> new_pstate[5]);

    // R8
    gsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones(new_pstate & 12'hC01) == 1 && new_pstate[2] && new_pstate[4]));

    // R11
    npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (new_npc == new_pc + 64'd4));
endmodule

bind trap_entry_ctrl trap_entry_chk #(.MAXTL(MAXTL), .TLW(TLW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_vld   (trap_vld),
    .cur_tl     (cur_tl),
    .new_tl     (new_tl),
    .new_pstate (new_pstate),
    .new_pc     (new_pc),
    .new_npc    (new_npc),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;
    localparam int NWIN  = 8;
    localparam int MAXTL = 6;
    localparam int TLW   = 3;
    localparam int CWPW  = 3;

    typedef struct {
        int          tl;
        logic [8:0]  tt;
        logic [7:0]  ccr;
        logic [7:0]  asi;
        logic [11:0] pst;
        int          cwp;
        int          cansave;
        int          gl;
        logic [63:0] pc;
        logic [63:0] npc;
        logic [63:0] tba;
    } tin_t;

    typedef struct {
        int          tl;
        logic [11:0] pst;
        int          cwp;
        int          gl;
        logic [63:0] pc;
        logic [63:0] npc;
        logic [63:0] tstate;
        logic [63:0] tpc;
        logic [63:0] tnpc;
        logic [8:0]  tt;
    } texp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_vld = 1'b0;
    logic [8:0] trap_tt = '0;
    logic [TLW-1:0] cur_tl = '0;
    logic [7:0] cur_ccr = '0;
    logic [7:0] cur_asi = '0;
    logic [11:0] cur_pstate = '0;
    logic [CWPW-1:0] cur_cwp = '0;
    logic [CWPW-1:0] cur_cansave = '0;
    logic [2:0] cur_gl = '0;
    logic [63:0] cur_pc = '0;
    logic [63:0] cur_npc = '0;
    logic [63:0] trap_base = '0;
    logic [TLW-1:0] mon_lvl = '0;
    logic [TLW-1:0] main_lvl = '0;
    logic mon_busy = 1'b0;
    logic [TLW-1:0] rd_lvl;
    logic [TLW-1:0] new_tl;
    logic [11:0] new_pstate;
    logic [CWPW-1:0] new_cwp;
    logic [2:0] new_gl;
    logic [63:0] new_pc, new_npc, rd_tstate, rd_tpc, rd_tnpc;
    logic [8:0] rd_tt;
    logic done_o, err_o;

    int n_tests = 0;
    int n_fail = 0;
    texp_t q[$];
    texp_t shadow[MAXTL + 1];

    assign rd_lvl = mon_busy ? mon_lvl : main_lvl;

    always #2 clk = ~clk;

    trap_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .trap_vld(trap_vld), .trap_tt(trap_tt),
        .cur_tl(cur_tl), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
        .cur_pstate(cur_pstate), .cur_cwp(cur_cwp), .cur_cansave(cur_cansave),
        .cur_gl(cur_gl), .cur_pc(cur_pc), .cur_npc(cur_npc),
        .trap_base(trap_base), .rd_lvl(rd_lvl), .new_tl(new_tl),
        .new_pstate(new_pstate), .new_cwp(new_cwp), .new_gl(new_gl),
        .new_pc(new_pc), .new_npc(new_npc), .done_o(done_o), .err_o(err_o),
        .rd_tstate(rd_tstate), .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc), .rd_tt(rd_tt)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic texp_t model(input tin_t t);
        texp_t e;
        logic red;
        logic [11:0] sel;
        logic mmu;
        red = (t.tl == MAXTL - 1);
        e.tl = t.tl + 1;
        e.tstate = '0;
        e.tstate[42:40] = 3'(t.gl);
        e.tstate[39:32] = t.ccr;
        e.tstate[31:24] = t.asi;
        e.tstate[19:8] = (t.pst | (red ? 12'h020 : 12'h000)) & 12'hF3F;
        e.tstate[2:0] = 3'(t.cwp);
        mmu = (t.tt == 9'h008) || (t.tt == 9'h030) ||
              (t.tt >= 9'h064 && t.tt <= 9'h06F);
        if (mmu) sel = 12'h414;
        else if (t.tt == 9'h060) sel = 12'h814;
        else sel = 12'h015;
        e.pst = sel | (red ? 12'h020 : 12'h000);
        if (t.tt == 9'h024) e.cwp = (t.cwp + NWIN - 1) % NWIN;
        else if (t.tt[8:6] == 3'b010) e.cwp = (t.cwp + 2 * NWIN - t.cansave - 2) % NWIN;
        else if (t.tt[8:6] == 3'b011) e.cwp = (t.cwp + 1) % NWIN;
        else e.cwp = t.cwp;
        e.gl = (t.gl + 1) % 8;
        e.pc = {t.tba[63:15], 15'h0000};
        if (e.tl > 1) e.pc[14] = 1'b1;
        e.pc[13:5] = t.tt;
        e.npc = e.pc + 64'd4;
        e.tpc = t.pc;
        e.tnpc = t.npc;
        e.tt = t.tt;
        return e;
    endfunction

    task automatic send(input tin_t t);
        texp_t e;
        e = model(t);
        q.push_back(e);
        shadow[e.tl] = e;
        trap_tt = t.tt; cur_tl = TLW'(t.tl); cur_ccr = t.ccr; cur_asi = t.asi;
        cur_pstate = t.pst; cur_cwp = CWPW'(t.cwp); cur_cansave = CWPW'(t.cansave);
        cur_gl = 3'(t.gl); cur_pc = t.pc; cur_npc = t.npc; trap_base = t.tba;
        trap_vld = 1'b1;
        @(negedge clk);
    endtask

    task automatic rest(input int n);
        trap_vld = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic tin_t mk(input int tl, input logic [8:0] tt, input int cwp,
                                input int cs, input int gl, input logic [63:0] seed);
        tin_t t;
        t.tl = tl; t.tt = tt; t.cwp = cwp; t.cansave = cs; t.gl = gl;
        t.ccr = seed[7:0] ^ 8'hA5; t.asi = seed[15:8] ^ 8'h3C;
        t.pst = 12'hFFF ^ seed[11:0];
        t.pc = 64'h0000_1000_0000_0000 + seed;
        t.npc = t.pc + 64'd4;
        t.tba = 64'hFFFF_0000_1234_5678 ^ (seed << 20);
        return t;
    endfunction

    // monitor: compares each completed trap against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (q.size() == 0) begin
                    chk("R12", "done without pending trap", 64'd1, 64'd0);
                end else begin
                    texp_t e;
                    e = q.pop_front();
                    mon_lvl = TLW'(e.tl);
                    mon_busy = 1'b1;
                    #1;
                    chk((e.tl == MAXTL) ? "R3" : "R2", "new_tl", 64'(new_tl), 64'(e.tl));
                    chk("R8/R9 R3", "new_pstate", 64'(new_pstate), 64'(e.pst));
                    chk("R10", "new_cwp", 64'(new_cwp), 64'(e.cwp));
                    chk("R6", "new_gl", 64'(new_gl), 64'(e.gl));
                    chk("R11", "new_pc", new_pc, e.pc);
                    chk("R11", "new_npc", new_npc, e.npc);
                    chk("R5", "tstate", rd_tstate, e.tstate);
                    chk("R7", "tpc", rd_tpc, e.tpc);
                    chk("R7", "tnpc", rd_tnpc, e.tnpc);
                    chk("R7", "tt", 64'(rd_tt), 64'(e.tt));
                    mon_busy = 1'b0;
                end
            end
        end
    end

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] hold_tl;
        logic [63:0] hold_pc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        main_lvl = 3'd1;
        #1;
        chk("R1", "new_tl", 64'(new_tl), 64'd0);
        chk("R1", "new_pc", new_pc, 64'd0);
        chk("R1", "done/err", {62'd0, done_o, err_o}, 64'd0);
        chk("R1", "stack level1", rd_tstate | rd_tpc, 64'd0);
        @(negedge clk);

        // R10 clean window from 0 wraps to 7
        send(mk(0, 9'h024, 0, 0, 2, 64'h11)); rest(2);
        // R10 spill: 3-5-2 wraps to 4, level 2 sets vector bit 14 (R11)
        send(mk(1, 9'h080, 3, 5, 7, 64'h22)); rest(2);
        // R10 fill: 7+1 wraps to 0
        send(mk(2, 9'h0C5, 7, 1, 0, 64'h33)); rest(2);
        // R9 interrupt vector
        send(mk(3, 9'h060, 2, 0, 3, 64'h44)); rest(2);
        // R8 MMU group member
        send(mk(4, 9'h06D, 5, 0, 4, 64'h55)); rest(2);
        // R3 entry at MAXTL-1 sets RED
        send(mk(5, 9'h008, 1, 0, 5, 64'h66)); rest(2);
        // R12 back-to-back: second strobe in done cycle
        send(mk(0, 9'h030, 4, 0, 1, 64'h77));
        send(mk(1, 9'h041, 6, 0, 6, 64'h88)); rest(3);
        chk("R12", "scoreboard drained", 64'(q.size()), 64'd0);

        // R7 levels not written since keep earlier entries
        for (int lv = 3; lv <= MAXTL; lv++) begin
            main_lvl = TLW'(lv);
            #1;
            chk("R7", "retained tpc", rd_tpc, shadow[lv].tpc);
            chk("R7", "retained tt", 64'(rd_tt), 64'(shadow[lv].tt));
        end
        main_lvl = 3'd0;
        #1;
        chk("R7", "level 0 reads zero", rd_tpc, 64'd0);
        @(negedge clk);

        // R4 overflow
        hold_tl = new_tl;
        hold_pc = new_pc;
        trap_tt = 9'h050; cur_tl = 3'(MAXTL); trap_vld = 1'b1;
        @(negedge clk);
        trap_vld = 1'b0;
        chk("R4", "err_o raised", 64'(err_o), 64'd1);
        chk("R4", "no done on overflow", 64'(done_o), 64'd0);
        chk("R4", "tl unchanged", 64'(new_tl), 64'(hold_tl));
        // R4 later strobe ignored
        trap_tt = 9'h024; cur_tl = 3'd0; trap_vld = 1'b1;
        @(negedge clk);
        trap_vld = 1'b0;
        @(negedge clk);
        main_lvl = 3'd1;
        #1;
        chk("R4", "err sticky", 64'(err_o), 64'd1);
        chk("R4", "no done after halt", 64'(done_o), 64'd0);
        chk("R4", "pc unchanged", new_pc, hold_pc);
        chk("R4", "level1 stack unchanged", rd_tpc, shadow[1].tpc);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule